// File: doc/BRIEF.md
# CAN Transmit Mailbox Arbitration Selector

This block decides which queued transmit mailbox goes onto the bus at the next opportunity. It keeps a pending flag for every mailbox slot. The mailbox contents sit outside the block and are presented as flat vectors: the extended-format flag, a 29-bit identifier field and a 3-bit local priority. A scan strobe starts a walk over the slots, one slot per clock. When the walk finishes, the block presents the winning slot index together with a valid flag.

Three policies can be chosen at run time: smallest identifier, lowest slot number, or largest local priority. A slot count input limits how many slots take part, so payload-dependent layouts (7, 12, 21 or 32 slots) can share the same table.

The bit engine takes the winner with a grant. From then on the slot counts as transmitting until the engine reports completion. An abort input withdraws a queued slot. If the withdrawn slot is the presented winner, or a walk is under way, a fresh walk starts on its own.

Top module: `can_txarb_sel`

## Requirements
- R1: After reset, `busy`, `win_valid` and `tx_active` are low and no slot is pending.
- R2: A `scan_start` pulse sampled at clock edge E makes `busy` high and `win_valid` low after E. The result appears, and `busy` falls, at edge E+MB_MAX. A new `scan_start` restarts a walk that is already under way.
- R3: Policy `cfg_mode`=2'b00 picks the eligible slot with the smallest 30-bit key, with ties going to the lowest index. The key is built as follows:
  - extended slot: {id[28:18], 1, id[17:0]}
  - standard slot: {id[10:0], 0, 18 zero bits}
  - Because of this layout, a standard frame beats an extended frame that has the same top 11 bits.
- R4: Policy 2'b01 (and the spare code 2'b11) picks the eligible slot with the lowest index.
- R5: Policy 2'b10 picks the eligible slot with the largest 3-bit priority. Ties go to the smaller key, then to the lowest index.
- R6: Slots whose index is at or above `cfg_count` are never chosen.
- R7: When no slot is eligible at the end of a walk, `win_valid` stays low.
- R8: `arm_en` marks slot `arm_idx` pending. Arming the slot that is currently transmitting is ignored.
- R9: A `grant` while `win_valid` is high and `tx_active` is low does three things at the next edge:
  - moves the winner into `tx_idx` and raises `tx_active`;
  - clears the winner's pending flag;
  - drops `win_valid`.
  A transmitting slot is excluded from walks until `tx_done` is seen. A `grant` at any other time is ignored.
- R10: `abort_en` clears the pending flag of slot `abort_idx`. If that slot is the presented winner, or a walk is under way, `win_valid` drops and a new walk starts at the same edge.
- R11: Aborting the slot that is transmitting has no effect: `tx_active` and `tx_idx` are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_mode | input | 2 | Arbitration policy |
| cfg_count | input | 6 | Number of slots taking part |
| mb_ide | input | 32 | Extended-format flag per slot |
| mb_id | input | 928 | 29-bit identifier per slot, slot i at [29i+28:29i] |
| mb_prio | input | 96 | 3-bit local priority per slot |
| arm_en | input | 1 | Mark a slot pending |
| arm_idx | input | 5 | Slot to mark |
| abort_en | input | 1 | Withdraw a pending slot |
| abort_idx | input | 5 | Slot to withdraw |
| scan_start | input | 1 | Start a walk |
| grant | input | 1 | Bit engine takes the winner |
| tx_done | input | 1 | Bit engine finished transmitting |
| busy | output | 1 | Walk in progress |
| win_valid | output | 1 | Winner presented |
| win_idx | output | 5 | Winning slot |
| tx_active | output | 1 | A slot is transmitting |
| tx_idx | output | 5 | Transmitting slot |

## Verification
Two kinds of corrupted internal state show up at the ports:
- A corrupted pending flag or best-candidate register becomes visible only at the edge where the walk completes. At that edge `win_idx` or `win_valid` differs from what the policy dictates.
- A faulty walk pointer moves the edge where `busy` falls away from exactly MB_MAX edges after the start.

Faults in abort handling surface within one edge, because the restart makes `busy` rise immediately. Faults in the transmit state surface at the grant edge, and again at the next walk, where a stale slot would be chosen a second time.

// File: rtl/txarb_pkg.sv
package txarb_pkg;
    localparam int ID_W   = 29;
    localparam int STD_W  = 11;
    localparam int EXT_LO = ID_W - STD_W;
    localparam int KEY_W  = ID_W + 1;
    localparam int PRIO_W = 3;

    typedef enum logic [1:0] {
        ARB_LOW_ID    = 2'b00,
        ARB_LOW_NUM   = 2'b01,
        ARB_HIGH_PRIO = 2'b10,
        ARB_SPARE     = 2'b11
    } arb_mode_e;

    typedef struct packed {
        logic [PRIO_W-1:0] prio;
        logic [KEY_W-1:0]  key;
    } arb_rank_t;

    // Bus-order key: base bits, then the format bit, then the extension bits
    function automatic logic [KEY_W-1:0] arb_key(input logic ide, input logic [ID_W-1:0] id);
        if (ide)
            return {id[ID_W-1 -: STD_W], 1'b1, id[EXT_LO-1:0]};
        else
            return {id[STD_W-1:0], 1'b0, {EXT_LO{1'b0}}};
    endfunction

    // Strict comparison; an ascending walk gives the lowest index on ties
    function automatic logic arb_beats(input arb_mode_e mode, input arb_rank_t cand,
                                       input arb_rank_t best);
        case (mode)
            ARB_LOW_ID:    return cand.key < best.key;
            ARB_HIGH_PRIO: return (cand.prio > best.prio) ||
                                  ((cand.prio == best.prio) && (cand.key < best.key));
            default:       return 1'b0;
        endcase
    endfunction
endpackage

// File: rtl/txarb_pend.sv
module txarb_pend #(
    parameter int MB_MAX = 32,
    parameter int IDX_W  = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              arm_en,
    input  logic [IDX_W-1:0]  arm_idx,
    input  logic              abort_hit,
    input  logic [IDX_W-1:0]  abort_idx,
    input  logic              grant_ok,
    input  logic [IDX_W-1:0]  grant_idx,
    input  logic              tx_done,
    output logic [MB_MAX-1:0] pend,
    output logic              tx_active,
    output logic [IDX_W-1:0]  tx_idx
);
    for (genvar s = 0; s < MB_MAX; s++) begin : g_slot
        localparam logic [IDX_W-1:0] SLOT = IDX_W'(s);
        logic q;
        always_ff @(posedge clk) begin
            if (rst)
                q <= 1'b0;
            else if ((abort_hit && abort_idx == SLOT) || (grant_ok && grant_idx == SLOT))
                q <= 1'b0;
            else if (arm_en && arm_idx == SLOT && !(tx_active && tx_idx == SLOT))
                q <= 1'b1;
        end
        assign pend[s] = q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_active <= 1'b0;
            tx_idx    <= '0;
        end else if (grant_ok) begin
            tx_active <= 1'b1;
            tx_idx    <= grant_idx;
        end else if (tx_done) begin
            tx_active <= 1'b0;
        end
    end
endmodule

// File: rtl/txarb_scan.sv
module txarb_scan
    import txarb_pkg::*;
#(
    parameter int MB_MAX = 32,
    parameter int IDX_W  = 5,
    parameter int CNT_W  = 6
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     restart,
    input  logic                     clear_win,
    input  arb_mode_e                mode,
    input  logic [CNT_W-1:0]         count,
    input  logic [MB_MAX-1:0]        pend,
    input  logic                     tx_active,
    input  logic [IDX_W-1:0]         tx_idx,
    input  logic [MB_MAX-1:0]        mb_ide,
    input  logic [MB_MAX*ID_W-1:0]   mb_id,
    input  logic [MB_MAX*PRIO_W-1:0] mb_prio,
    output logic                     busy,
    output logic                     win_valid,
    output logic [IDX_W-1:0]         win_idx
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(MB_MAX - 1);

    logic [IDX_W-1:0] ptr;
    logic             best_found;
    logic [IDX_W-1:0] best_idx;
    arb_rank_t        best_rank;
    arb_rank_t        cand_rank;
    logic             cand_elig;
    logic             take;

    always_comb begin
        cand_rank.key  = arb_key(mb_ide[ptr], mb_id[int'(ptr)*ID_W +: ID_W]);
        cand_rank.prio = mb_prio[int'(ptr)*PRIO_W +: PRIO_W];
        cand_elig = pend[ptr] && ({1'b0, ptr} < count) && !(tx_active && tx_idx == ptr);
        take      = cand_elig && (!best_found || arb_beats(mode, cand_rank, best_rank));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy       <= 1'b0;
            ptr        <= '0;
            best_found <= 1'b0;
            best_idx   <= '0;
            best_rank  <= '0;
            win_valid  <= 1'b0;
            win_idx    <= '0;
        end else if (restart) begin
            busy       <= 1'b1;
            ptr        <= '0;
            best_found <= 1'b0;
            win_valid  <= 1'b0;
        end else begin
            if (clear_win)
                win_valid <= 1'b0;
            if (busy) begin
                if (take) begin
                    best_found <= 1'b1;
                    best_idx   <= ptr;
                    best_rank  <= cand_rank;
                end
                if (ptr == LAST) begin
                    busy      <= 1'b0;
                    win_valid <= best_found || take;
                    win_idx   <= take ? ptr : best_idx;
                end else begin
                    ptr <= ptr + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/can_txarb_sel.sv
module can_txarb_sel
    import txarb_pkg::*;
#(
    parameter int MB_MAX = 32,
    localparam int IDX_W = $clog2(MB_MAX),
    localparam int CNT_W = $clog2(MB_MAX + 1)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [1:0]               cfg_mode,
    input  logic [CNT_W-1:0]         cfg_count,
    input  logic [MB_MAX-1:0]        mb_ide,
    input  logic [MB_MAX*ID_W-1:0]   mb_id,
    input  logic [MB_MAX*PRIO_W-1:0] mb_prio,
    input  logic                     arm_en,
    input  logic [IDX_W-1:0]         arm_idx,
    input  logic                     abort_en,
    input  logic [IDX_W-1:0]         abort_idx,
    input  logic                     scan_start,
    input  logic                     grant,
    input  logic                     tx_done,
    output logic                     busy,
    output logic                     win_valid,
    output logic [IDX_W-1:0]         win_idx,
    output logic                     tx_active,
    output logic [IDX_W-1:0]         tx_idx
);
    logic [MB_MAX-1:0] pend;
    logic              abort_hit;
    logic              restart;
    logic              grant_ok;

    // An abort only counts when the slot is queued; a transmitting slot is not
    assign abort_hit = abort_en && pend[abort_idx];
    assign restart   = scan_start ||
                       (abort_hit && (busy || (win_valid && win_idx == abort_idx)));
    assign grant_ok  = grant && win_valid && !tx_active && !restart;

    txarb_pend #(.MB_MAX(MB_MAX), .IDX_W(IDX_W)) u_pend (
        .clk       (clk),
        .rst       (rst),
        .arm_en    (arm_en),
        .arm_idx   (arm_idx),
        .abort_hit (abort_hit),
        .abort_idx (abort_idx),
        .grant_ok  (grant_ok),
        .grant_idx (win_idx),
        .tx_done   (tx_done),
        .pend      (pend),
        .tx_active (tx_active),
        .tx_idx    (tx_idx)
    );

    txarb_scan #(.MB_MAX(MB_MAX), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_scan (
        .clk       (clk),
        .rst       (rst),
        .restart   (restart),
        .clear_win (grant_ok),
        .mode      (arb_mode_e'(cfg_mode)),
        .count     (cfg_count),
        .pend      (pend),
        .tx_active (tx_active),
        .tx_idx    (tx_idx),
        .mb_ide    (mb_ide),
        .mb_id     (mb_id),
        .mb_prio   (mb_prio),
        .busy      (busy),
        .win_valid (win_valid),
        .win_idx   (win_idx)
    );
endmodule

// File: rtl/txarb_chk.sv
module txarb_chk #(
    parameter int MB_MAX = 32,
    parameter int IDX_W  = 5
) (
    input logic              clk,
    input logic              rst,
    input logic              scan_start,
    input logic              grant,
    input logic              abort_en,
    input logic              tx_done,
    input logic              busy,
    input logic              win_valid,
    input logic [IDX_W-1:0]  win_idx,
    input logic              tx_active,
    input logic [IDX_W-1:0]  tx_idx,
    input logic [MB_MAX-1:0] pend
);
    AST_START_BUSY: assert property (@(posedge clk) disable iff (rst)
        scan_start |=> busy && !win_valid); // R2
    AST_VALID_IDLE: assert property (@(posedge clk) disable iff (rst)
        win_valid |-> !busy); // R2
    AST_WIN_PENDING: assert property (@(posedge clk) disable iff (rst)
        win_valid |-> pend[win_idx]); // R10
    AST_WIN_NOT_TX: assert property (@(posedge clk) disable iff (rst)
        win_valid |-> !(tx_active && tx_idx == win_idx)); // R9
    AST_TX_HOLD: assert property (@(posedge clk) disable iff (rst)
        (tx_active && !tx_done) |=> tx_active && $stable(tx_idx)); // R11
    AST_GRANT_TAKE: assert property (@(posedge clk) disable iff (rst)
        (grant && win_valid && !tx_active && !scan_start && !abort_en)
        |=> tx_active && tx_idx == $past(win_idx) && !win_valid); // R9
endmodule

bind can_txarb_sel txarb_chk #(.MB_MAX(MB_MAX), .IDX_W(IDX_W)) u_txarb_chk (
    .clk        (clk),
    .rst        (rst),
    .scan_start (scan_start),
    .grant      (grant),
    .abort_en   (abort_en),
    .tx_done    (tx_done),
    .busy       (busy),
    .win_valid  (win_valid),
    .win_idx    (win_idx),
    .tx_active  (tx_active),
    .tx_idx     (tx_idx),
    .pend       (pend)
);

// File: tb/test_can_txarb_sel.sv
module test_can_txarb_sel;
    localparam int CLK_PERIOD = 10;
    localparam int MB = 32;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [1:0] cfg_mode = 2'b01;
    logic [5:0] cfg_count = 6'd32;
    logic [MB-1:0] mb_ide;
    logic [MB*29-1:0] mb_id;
    logic [MB*3-1:0] mb_prio;
    logic arm_en = 0, abort_en = 0, scan_start = 0, grant = 0, tx_done = 0;
    logic [4:0] arm_idx = 0, abort_idx = 0;
    logic busy, win_valid, tx_active;
    logic [4:0] win_idx, tx_idx;

    logic        b_ide  [MB];
    logic [28:0] b_id   [MB];
    logic [2:0]  b_prio [MB];

    always_comb begin
        for (int i = 0; i < MB; i++) begin
            mb_ide[i]           = b_ide[i];
            mb_id[i*29 +: 29]   = b_id[i];
            mb_prio[i*3 +: 3]   = b_prio[i];
        end
    end

    can_txarb_sel i_can_txarb_sel (
        .clk(clk), .rst(rst), .cfg_mode(cfg_mode), .cfg_count(cfg_count),
        .mb_ide(mb_ide), .mb_id(mb_id), .mb_prio(mb_prio),
        .arm_en(arm_en), .arm_idx(arm_idx), .abort_en(abort_en), .abort_idx(abort_idx),
        .scan_start(scan_start), .grant(grant), .tx_done(tx_done),
        .busy(busy), .win_valid(win_valid), .win_idx(win_idx),
        .tx_active(tx_active), .tx_idx(tx_idx)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int errors = 0;
    string cur_req = "R1";

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Behavioural reference model
    bit m_pend [MB];
    bit m_busy, m_wv, m_tx;
    int m_left, m_wi, m_ti;

    function automatic longint key_of(int i);
        longint idv = longint'(b_id[i]);
        if (b_ide[i])
            return ((idv / 262144) * 524288) + 262144 + (idv % 262144);
        return (idv % 2048) * 524288;
    endfunction

    function automatic void pick(output bit v, output int w);
        longint bk = 0;
        int bp = 0;
        v = 0; w = 0;
        for (int i = 0; i < int'(cfg_count); i++) begin
            if (m_pend[i] && !(m_tx && m_ti == i)) begin
                longint k = key_of(i);
                int p = int'(b_prio[i]);
                bit better;
                if (!v) better = 1;
                else if (cfg_mode == 2'b00) better = (k < bk);
                else if (cfg_mode == 2'b10) better = (p > bp) || (p == bp && k < bk);
                else better = 0;
                if (better) begin v = 1; w = i; bk = k; bp = p; end
            end
        end
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            foreach (m_pend[i]) m_pend[i] = 0;
            m_busy = 0; m_wv = 0; m_tx = 0; m_left = 0; m_wi = 0; m_ti = 0;
        end else begin
            bit ab, rs, gk, nv;
            int nw, old_wi;
            bit old_tx;
            int old_ti;
            ab = abort_en && m_pend[abort_idx];
            rs = scan_start || (ab && (m_busy || (m_wv && m_wi == int'(abort_idx))));
            gk = grant && m_wv && !m_tx && !rs;
            old_wi = m_wi; old_tx = m_tx; old_ti = m_ti;
            pick(nv, nw);
            if (rs) begin
                m_busy = 1; m_left = MB; m_wv = 0;
            end else begin
                if (gk) m_wv = 0;
                if (m_busy) begin
                    m_left--;
                    if (m_left == 0) begin m_busy = 0; m_wv = nv; m_wi = nw; end
                end
            end
            if (gk) begin m_tx = 1; m_ti = old_wi; end
            else if (tx_done) m_tx = 0;
            if (arm_en && !(old_tx && old_ti == int'(arm_idx))) m_pend[arm_idx] = 1;
            if (ab) m_pend[abort_idx] = 0;
            if (gk) m_pend[old_wi] = 0;
        end
    end

    // Compare every clock, away from the active edge
    always @(negedge clk) begin
        if (!rst) begin
            chk(cur_req, "busy", int'(busy), int'(m_busy));
            chk(cur_req, "win_valid", int'(win_valid), int'(m_wv));
            if (m_wv) chk(cur_req, "win_idx", int'(win_idx), m_wi);
            chk(cur_req, "tx_active", int'(tx_active), int'(m_tx));
            if (m_tx) chk(cur_req, "tx_idx", int'(tx_idx), m_ti);
        end
    end

    task automatic idle(int n); repeat (n) @(negedge clk); endtask
    task automatic arm(int i); arm_en = 1; arm_idx = 5'(i); @(negedge clk); arm_en = 0; endtask
    task automatic abort_mb(int i); abort_en = 1; abort_idx = 5'(i); @(negedge clk); abort_en = 0; endtask
    task automatic do_grant; grant = 1; @(negedge clk); grant = 0; endtask
    task automatic end_tx; tx_done = 1; @(negedge clk); tx_done = 0; endtask
    task automatic scan; scan_start = 1; @(negedge clk); scan_start = 0; idle(MB); endtask
    task automatic expect_win(string req, bit v, int w);
        chk(req, "result valid", int'(win_valid), int'(v));
        if (v) chk(req, "result index", int'(win_idx), w);
    endtask
    task automatic expect_tx(string req, bit a, int i);
        chk(req, "transmitting", int'(tx_active), int'(a));
        if (a) chk(req, "transmit index", int'(tx_idx), i);
    endtask
    task automatic finish_run;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        errors++;
        $display("FAIL R2 watchdog: actual=running expected=done");
        finish_run();
    end

    initial begin
        for (int i = 0; i < MB; i++) begin b_ide[i] = 0; b_id[i] = 0; b_prio[i] = 0; end
        idle(3);
        rst = 0;
        idle(1);
        // R1: reset state
        expect_win("R1", 0, 0);
        expect_tx("R1", 0, 0);
        chk("R1", "busy", int'(busy), 0);
        // R9: grant with no winner is ignored
        cur_req = "R9";
        do_grant();
        expect_tx("R9", 0, 0);

        // R8 / R4: arm and pick lowest slot
        cur_req = "R4";
        b_ide[5] = 1; b_id[5] = 29'h8000000;        // extended, base 0x200
        b_ide[9] = 0; b_id[9] = 29'h100;            // standard 0x100
        b_ide[20] = 1; b_id[20] = 29'(32'h100 << 18); // extended, base 0x100
        b_ide[25] = 0; b_id[25] = 29'h100;          // standard 0x100
        b_prio[5] = 3; b_prio[9] = 6; b_prio[20] = 6; b_prio[25] = 6;
        arm(5); arm(9); arm(20); arm(25);
        scan();
        expect_win("R4", 1, 5);
        cfg_mode = 2'b11;
        scan();
        expect_win("R4", 1, 5);

        // R3: lowest key; standard beats extended with equal base, lower index on tie
        cur_req = "R3";
        cfg_mode = 2'b00;
        scan();
        expect_win("R3", 1, 9);

        // R5: highest priority, tie by key then index
        cur_req = "R5";
        cfg_mode = 2'b10;
        scan();
        expect_win("R5", 1, 9);
        b_prio[25] = 7;
        scan();
        expect_win("R5", 1, 25);

        // R6 / R7: slot count limit
        cur_req = "R6";
        cfg_count = 6'd21;
        scan();
        expect_win("R6", 1, 9);
        cfg_mode = 2'b01; cfg_count = 6'd7;
        scan();
        expect_win("R6", 1, 5);
        cur_req = "R7";
        cfg_count = 6'd5;
        scan();
        expect_win("R7", 0, 0);
        cfg_count = 6'd32;

        // R9: grant moves winner into transmission
        cur_req = "R9";
        scan();
        expect_win("R9", 1, 5);
        do_grant();
        expect_tx("R9", 1, 5);
        expect_win("R9", 0, 0);
        scan();
        expect_win("R9", 1, 9);
        // R8: arming the transmitting slot is ignored
        cur_req = "R8";
        arm(5);
        end_tx();
        scan();
        expect_win("R8", 1, 9);

        // R11: abort of the transmitting slot has no effect
        cur_req = "R11";
        do_grant();
        expect_tx("R11", 1, 9);
        abort_mb(9);
        expect_tx("R11", 1, 9);
        end_tx();
        scan();
        expect_win("R11", 1, 20);

        // R10: abort of winner forces a new walk
        cur_req = "R10";
        abort_mb(20);
        chk("R10", "busy after abort", int'(busy), 1);
        idle(MB);
        expect_win("R10", 1, 25);
        // R10: abort during a walk restarts it
        scan_start = 1; @(negedge clk); scan_start = 0;
        idle(10);
        abort_mb(25);
        idle(MB);
        expect_win("R10", 0, 0);
        chk("R10", "busy at end", int'(busy), 0);

        idle(2);
        finish_run();
    end
endmodule